// File: doc/BRIEF.md
# Power-Sequenced Windowed Channel Accumulator

This block runs a measurement cycle that repeats without end. Each cycle first raises a power-enable output, which switches on an external supply through a relay. It then waits for a settling interval. After that it opens an acquisition window. During the window it scans a set of ADC channels in round-robin order, one conversion request at a time. It adds each signed raw conversion code into a per-channel sum and counts the scans that complete. When the window closes, the supply is switched off, the sums and the scan count are copied into output registers, and a one-cycle result pulse is raised.

The host takes the registered sums and the count and divides them to get per-channel averages. The host also converts raw codes to volts. The cycle period, settling time, window length and conversion time are all parameters given in clock cycles. The channel count is also a parameter: six channels is the default, and the design scales to about thirty. The ADC is reached through a request/valid pair. Each response must come back 1 to `CONV_CLKS-1` cycles after its request, and responses return in request order.

Top module: `scan_window_accum`

## Requirements
- R1: `pwrEn` is low while `rst` is high. After reset the cycle counter starts at 0 and wraps every `CYCLE_CLKS` cycles. `pwrEn` is high for counter values 0 to `SETTLE_CLKS+WINDOW_CLKS-1` and low for the rest of the cycle.
- R2: The acquisition window covers counter values from `SETTLE_CLKS` to `SETTLE_CLKS+WINDOW_CLKS-1`. Scan k starts at `SETTLE_CLKS + k*NUM_CH*CONV_CLKS`. Within a scan, the request for channel j is a one-cycle `adcReq` at `CONV_CLKS*j` cycles after the scan start, with `adcChan` = j (channels 0 first, up to `NUM_CH-1`). Two requests are never fewer than `CONV_CLKS` cycles apart.
- R3: A scan starts only if at least `NUM_CH*CONV_CLKS` cycles of the window remain. As a result no partial scan enters the sums, and a window holds `floor(WINDOW_CLKS / (NUM_CH*CONV_CLKS))` scans unless R6 caps it.
- R4: Each `adcValid` adds `adcCode`, read as a 16-bit two's-complement value and sign-extended to 32 bits, into the sum of the channel whose request is the oldest one not yet answered.
- R5: The sums and the scan count clear when the window opens. The count rises by one when the last channel's response of a scan is added.
- R6: No more than `MAX_SCANS` scans (default 65536) are started in a window. After that limit, no request is issued for the rest of the window.
- R7: The sums and count are registered when the counter reaches `SETTLE_CLKS+WINDOW_CLKS`. The new values appear together with a one-cycle `resultValid` on the next cycle. The outputs keep those values until the next result and read zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrEn | output | 1 | Supply enable for the external relay |
| adcReq | output | 1 | One-cycle conversion request |
| adcChan | output | CH_W | Channel of the current request |
| adcValid | input | 1 | Conversion result valid |
| adcCode | input | CODE_W | Raw signed conversion code |
| chanSums | output | NUM_CH*SUM_W | Registered per-channel sums, channel 0 in the low bits |
| scanCount | output | CNT_W | Registered number of completed scans |
| resultValid | output | 1 | One-cycle pulse when new results are presented |

## Verification
The bench delivers codes that include both the full-scale positive and the full-scale negative values. A design that zero-extended the codes, or that routed a response to the wrong channel, would report wrong sums. The window length is not a multiple of the scan time, so a design that started a scan too late would either issue requests past the window or count a partial scan. A second copy of the block runs with a small scan cap, which catches a count that runs past the limit or requests that continue after it. The reference also checks that the count comes back to the same value in every window, which catches a design that fails to clear between windows. It checks that the outputs hold between result pulses, which catches results that leak early or a pulse with the wrong width.

// File: rtl/scan_accum_pkg.sv
package scan_accum_pkg;
  // Strobes from the cycle controller to the accumulation datapath.
  typedef struct packed {
    logic clearAcc;  // window opens: wipe running sums and count
    logic latchOut;  // window closed: copy sums and count to outputs
  } accStrobe_t;
endpackage

// File: rtl/scan_accum_ctrl.sv
module scan_accum_ctrl
  import scan_accum_pkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int CYCLE_CLKS  = 2_000_000_000,
  parameter int SETTLE_CLKS = 300_000_000,
  parameter int WINDOW_CLKS = 100_000_000,
  parameter int CONV_CLKS   = 400,
  parameter int MAX_SCANS   = 65536,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  output logic            pwrEn,
  output logic            adcReq,
  output logic [CH_W-1:0] adcChan,
  output accStrobe_t      strobe
);
  localparam int CYC_W  = $clog2(CYCLE_CLKS + 1);
  localparam int TMR_W  = (CONV_CLKS > 1) ? $clog2(CONV_CLKS) : 1;
  localparam int SCN_W  = $clog2(MAX_SCANS + 1);
  localparam int ACQ_END   = SETTLE_CLKS + WINDOW_CLKS;
  localparam int SCAN_CLKS = NUM_CH * CONV_CLKS;

  localparam logic [CYC_W-1:0] CYC_LAST  = CYC_W'(CYCLE_CLKS - 1);
  localparam logic [CYC_W-1:0] ACQ_BEGIN = CYC_W'(SETTLE_CLKS);
  localparam logic [CYC_W-1:0] ACQ_STOP  = CYC_W'(ACQ_END);
  localparam logic [CYC_W-1:0] SCAN_LEN  = CYC_W'(SCAN_CLKS);
  localparam logic [TMR_W-1:0] TMR_RELOAD = TMR_W'(CONV_CLKS - 1);
  localparam logic [CH_W-1:0]  CH_LAST   = CH_W'(NUM_CH - 1);
  localparam logic [SCN_W-1:0] SCAN_CAP  = SCN_W'(MAX_SCANS);

  logic [CYC_W-1:0] cyc;
  logic [TMR_W-1:0] convTmr;
  logic [CH_W-1:0]  chIdx;
  logic [SCN_W-1:0] scansStarted;
  logic [CYC_W-1:0] remaining;
  logic             inAcq;
  logic             scanRoom;
  logic             issue;

  assign inAcq     = (cyc >= ACQ_BEGIN) && (cyc < ACQ_STOP);
  assign remaining = ACQ_STOP - cyc;
  assign scanRoom  = (scansStarted < SCAN_CAP) && (remaining >= SCAN_LEN);
  assign issue     = inAcq && (convTmr == '0) && ((chIdx != '0) || scanRoom);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc          <= '0;
      convTmr      <= '0;
      chIdx        <= '0;
      scansStarted <= '0;
    end else begin
      cyc <= (cyc == CYC_LAST) ? '0 : cyc + CYC_W'(1);
      if (!inAcq) begin
        convTmr      <= '0;
        chIdx        <= '0;
        scansStarted <= '0;
      end else if (issue) begin
        convTmr <= TMR_RELOAD;
        chIdx   <= (chIdx == CH_LAST) ? '0 : chIdx + CH_W'(1);
        if (chIdx == '0) scansStarted <= scansStarted + SCN_W'(1);
      end else if (convTmr != '0) begin
        convTmr <= convTmr - TMR_W'(1);
      end
    end
  end

  assign pwrEn           = !rst && (cyc < ACQ_STOP);
  assign adcReq          = issue;
  assign adcChan         = chIdx;
  assign strobe.clearAcc = (cyc == ACQ_BEGIN);
  assign strobe.latchOut = (cyc == ACQ_STOP);
endmodule

// File: rtl/scan_accum_path.sv
module scan_accum_path
  import scan_accum_pkg::*;
#(
  parameter int NUM_CH    = 6,
  parameter int CODE_W    = 16,
  parameter int SUM_W     = 32,
  parameter int MAX_SCANS = 65536,
  localparam int CNT_W = $clog2(MAX_SCANS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  accStrobe_t              strobe,
  input  logic                    adcValid,
  input  logic [CODE_W-1:0]       adcCode,
  output logic [NUM_CH*SUM_W-1:0] chanSums,
  output logic [CNT_W-1:0]        scanCount,
  output logic                    resultValid
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(NUM_CH - 1);
  localparam logic [CNT_W-1:0] SCAN_CAP = CNT_W'(MAX_SCANS);

  logic [CH_W-1:0]  rxCh;      // channel the next response belongs to
  logic [CNT_W-1:0] scansDone;
  logic [CNT_W-1:0] countOut;
  logic             pulse;
  logic [SUM_W-1:0] codeExt;

  assign codeExt = {{(SUM_W-CODE_W){adcCode[CODE_W-1]}}, adcCode};

  always_ff @(posedge clk) begin
    if (rst || strobe.clearAcc) begin
      rxCh      <= '0;
      scansDone <= '0;
    end else if (adcValid) begin
      if (rxCh == CH_LAST) begin
        rxCh <= '0;
        if (scansDone < SCAN_CAP) scansDone <= scansDone + CNT_W'(1);
      end else begin
        rxCh <= rxCh + CH_W'(1);
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic [SUM_W-1:0] accReg;
    logic [SUM_W-1:0] outReg;
    always_ff @(posedge clk) begin
      if (rst || strobe.clearAcc)            accReg <= '0;
      else if (adcValid && rxCh == CH_W'(g)) accReg <= accReg + codeExt;
    end
    always_ff @(posedge clk) begin
      if (rst)                  outReg <= '0;
      else if (strobe.latchOut) outReg <= accReg;
    end
    assign chanSums[g*SUM_W +: SUM_W] = outReg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      countOut <= '0;
      pulse    <= 1'b0;
    end else begin
      pulse <= strobe.latchOut;
      if (strobe.latchOut) countOut <= scansDone;
    end
  end

  assign scanCount   = countOut;
  assign resultValid = pulse;
endmodule

// File: rtl/scan_window_accum.sv
module scan_window_accum
  import scan_accum_pkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int CODE_W      = 16,
  parameter int SUM_W       = 32,
  parameter int CYCLE_CLKS  = 2_000_000_000,
  parameter int SETTLE_CLKS = 300_000_000,
  parameter int WINDOW_CLKS = 100_000_000,
  parameter int CONV_CLKS   = 400,
  parameter int MAX_SCANS   = 65536,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W = $clog2(MAX_SCANS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic                    pwrEn,
  output logic                    adcReq,
  output logic [CH_W-1:0]         adcChan,
  input  logic                    adcValid,
  input  logic [CODE_W-1:0]       adcCode,
  output logic [NUM_CH*SUM_W-1:0] chanSums,
  output logic [CNT_W-1:0]        scanCount,
  output logic                    resultValid
);
  accStrobe_t strobe;

  scan_accum_ctrl #(
    .NUM_CH(NUM_CH), .CYCLE_CLKS(CYCLE_CLKS), .SETTLE_CLKS(SETTLE_CLKS),
    .WINDOW_CLKS(WINDOW_CLKS), .CONV_CLKS(CONV_CLKS), .MAX_SCANS(MAX_SCANS)
  ) ctrl (
    .clk(clk), .rst(rst), .pwrEn(pwrEn), .adcReq(adcReq),
    .adcChan(adcChan), .strobe(strobe)
  );

  scan_accum_path #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .SUM_W(SUM_W), .MAX_SCANS(MAX_SCANS)
  ) path (
    .clk(clk), .rst(rst), .strobe(strobe), .adcValid(adcValid),
    .adcCode(adcCode), .chanSums(chanSums), .scanCount(scanCount),
    .resultValid(resultValid)
  );
endmodule

// File: rtl/scan_window_accum_chk.sv
module scan_window_accum_chk #(
  parameter int NUM_CH    = 6,
  parameter int SUM_W     = 32,
  parameter int CONV_CLKS = 400,
  parameter int MAX_SCANS = 65536,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W = $clog2(MAX_SCANS + 1)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    pwrEn,
  input logic                    adcReq,
  input logic [CH_W-1:0]         adcChan,
  input logic [NUM_CH*SUM_W-1:0] chanSums,
  input logic [CNT_W-1:0]        scanCount,
  input logic                    resultValid
);
  logic [31:0] sinceReq;
  logic        gotReq;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceReq <= '0;
      gotReq   <= 1'b0;
    end else if (adcReq) begin
      sinceReq <= 32'd1;
      gotReq   <= 1'b1;
    end else if (sinceReq != '1) begin
      sinceReq <= sinceReq + 32'd1;
    end
  end

  a_r2_req_spacing: assert property (@(posedge clk) disable iff (rst)
    (adcReq && gotReq) |-> (sinceReq >= CONV_CLKS));
  a_r2_chan_range: assert property (@(posedge clk) disable iff (rst)
    adcReq |-> (adcChan < CH_W'(NUM_CH)));
  a_r1_req_powered: assert property (@(posedge clk) disable iff (rst)
    adcReq |-> pwrEn);
  a_r1_off_at_result: assert property (@(posedge clk) disable iff (rst)
    resultValid |-> !pwrEn);
  a_r6_count_cap: assert property (@(posedge clk) disable iff (rst)
    scanCount <= CNT_W'(MAX_SCANS));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    resultValid |=> !resultValid);
  a_r7_outputs_hold: assert property (@(posedge clk) disable iff (rst)
    !resultValid |-> ($stable(scanCount) && $stable(chanSums)));
endmodule

bind scan_window_accum scan_window_accum_chk #(
  .NUM_CH(NUM_CH), .SUM_W(SUM_W), .CONV_CLKS(CONV_CLKS), .MAX_SCANS(MAX_SCANS)
) chkInst (
  .clk(clk), .rst(rst), .pwrEn(pwrEn), .adcReq(adcReq), .adcChan(adcChan),
  .chanSums(chanSums), .scanCount(scanCount), .resultValid(resultValid)
);

// File: tb/scan_window_accum_test.sv
`timescale 1ns/1ps
module scan_window_accum_test;
  localparam int NCH = 3, SW = 32, CONV = 4, SET = 10, WIN = 62, CYC = 100;
  localparam int MAXU = 1000, MAXC = 3;
  localparam int FIT  = WIN / (NCH * CONV);
  localparam int NS_U = (FIT < MAXU) ? FIT : MAXU;
  localparam int NS_C = (FIT < MAXC) ? FIT : MAXC;
  localparam int CWU = $clog2(MAXU + 1), CWC = $clog2(MAXC + 1);

  logic clk = 1'b0, rst;
  always #2 clk = ~clk;

  logic pwrU, reqU, validU, rvU, pwrC, reqC, validC, rvC;
  logic [1:0] chanU, chanC;
  logic [15:0] codeU, codeC;
  logic [NCH*SW-1:0] sumsU, sumsC;
  logic [CWU-1:0] cntU;
  logic [CWC-1:0] cntC;

  scan_window_accum #(.NUM_CH(NCH), .CYCLE_CLKS(CYC), .SETTLE_CLKS(SET),
    .WINDOW_CLKS(WIN), .CONV_CLKS(CONV), .MAX_SCANS(MAXU)) uut (
    .clk(clk), .rst(rst), .pwrEn(pwrU), .adcReq(reqU), .adcChan(chanU),
    .adcValid(validU), .adcCode(codeU), .chanSums(sumsU), .scanCount(cntU),
    .resultValid(rvU));

  scan_window_accum #(.NUM_CH(NCH), .CYCLE_CLKS(CYC), .SETTLE_CLKS(SET),
    .WINDOW_CLKS(WIN), .CONV_CLKS(CONV), .MAX_SCANS(MAXC)) uutCap (
    .clk(clk), .rst(rst), .pwrEn(pwrC), .adcReq(reqC), .adcChan(chanC),
    .adcValid(validC), .adcCode(codeC), .chanSums(sumsC), .scanCount(cntC),
    .resultValid(rvC));

  int nChecks = 0, nFails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int codeOf(input int k);
    if (k % 7 == 0) return 32767;
    if (k % 7 == 3) return -32768;
    return ((k * 7919) % 65536) - 32768;
  endfunction

  function automatic int sumAt(input logic [NCH*SW-1:0] v, input int ch);
    return int'($signed(v[ch*SW +: SW]));
  endfunction

  int expU[NCH], heldU[NCH], expC[NCH], heldC[NCH];
  int heldCntU = 0, heldCntC = 0, reqCntC = 0, kU = 0, kC = 200;
  bit pendU = 0, pendC = 0;
  int pendChU, pendCodeU, pendChC, pendCodeC;

  initial begin
    foreach (heldU[i]) begin heldU[i] = 0; heldC[i] = 0; expU[i] = 0; expC[i] = 0; end
    rst = 1'b1; validU = 0; validC = 0; codeU = '0; codeC = '0;
    repeat (3) @(negedge clk);
    // R1 / R7: reset state
    chk(pwrU == 1'b0, "R1 power low in reset", pwrU, 0);
    chk(rvU == 1'b0, "R7 no pulse in reset", rvU, 0);
    chk(cntU == '0, "R7 count zero after reset", cntU, 0);
    chk(sumsU == '0, "R7 sums zero after reset", sumsU == '0, 1);
    rst = 1'b0;
    for (int iter = 1; iter <= 3 * CYC + 12; iter++) begin
      int t, off;
      bit inAcq, eReqU, eReqC;
      @(negedge clk);
      t = iter % CYC;
      off = t - SET;
      inAcq = (t >= SET) && (t < SET + WIN);
      if (t == SET) begin
        foreach (expU[i]) begin expU[i] = 0; expC[i] = 0; end
        reqCntC = 0;
      end
      eReqU = inAcq && (off % CONV == 0) && ((off / CONV) / NCH < NS_U);
      eReqC = inAcq && (off % CONV == 0) && ((off / CONV) / NCH < NS_C);
      chk(pwrU == (t < SET + WIN), "R1 power enable", pwrU, t < SET + WIN);
      chk(reqU == eReqU, "R2 R3 request timing", reqU, eReqU);
      if (eReqU && reqU) chk(chanU == 2'((off / CONV) % NCH), "R2 channel order", chanU, (off / CONV) % NCH);
      chk(reqC == eReqC, "R6 request stops at cap", reqC, eReqC);
      if (reqC) reqCntC++;
      chk(rvU == (t == SET + WIN + 1), "R7 result pulse", rvU, t == SET + WIN + 1);
      if (t == SET + WIN + 1) begin
        chk(int'(cntU) == NS_U, "R3 R5 scan count per window", cntU, NS_U);
        chk(int'(cntC) == NS_C, "R6 capped scan count", cntC, NS_C);
        chk(reqCntC == NS_C * NCH, "R6 capped request total", reqCntC, NS_C * NCH);
        for (int ch = 0; ch < NCH; ch++) begin
          chk(sumAt(sumsU, ch) == expU[ch], "R4 channel sum", sumAt(sumsU, ch), expU[ch]);
          chk(sumAt(sumsC, ch) == expC[ch], "R6 capped channel sum", sumAt(sumsC, ch), expC[ch]);
          heldU[ch] = expU[ch];
          heldC[ch] = expC[ch];
        end
        heldCntU = NS_U;
        heldCntC = NS_C;
      end else begin
        chk(int'(cntU) == heldCntU, "R7 count holds", cntU, heldCntU);
        for (int ch = 0; ch < NCH; ch++)
          chk(sumAt(sumsU, ch) == heldU[ch], "R7 sums hold", sumAt(sumsU, ch), heldU[ch]);
      end
      // ADC models: answer one cycle after each request
      validU = 1'b0;
      if (pendU) begin
        validU = 1'b1; codeU = 16'(pendCodeU); expU[pendChU] += pendCodeU; pendU = 0;
      end
      if (reqU) begin
        pendU = 1; pendChU = int'(chanU); pendCodeU = codeOf(kU); kU++;
      end
      validC = 1'b0;
      if (pendC) begin
        validC = 1'b1; codeC = 16'(pendCodeC); expC[pendChC] += pendCodeC; pendC = 0;
      end
      if (reqC) begin
        pendC = 1; pendChC = int'(chanC); pendCodeC = codeOf(kC); kC++;
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule